// File: doc/BRIEF.md
# Precise Exception Sequencer

This block decides, every cycle, whether a five-stage in-order pipeline must abandon its current work and enter the exception handler. It watches two exception sources: an arithmetic overflow flag raised by the execute stage and a memory fault flag raised by the memory stage. Each flag comes with the program counter of the instruction that raised it. When an exception is accepted, the block does several things in the same cycle:

- It squashes the faulting instruction and every younger instruction through flushes of the IF/ID, ID/EX and EX/MEM latches.
- It blocks the write-back of an instruction that faults in the memory stage.
- It writes the faulting PC into the exception PC register and the reason into the cause register.
- It steers fetch to a fixed handler vector.

Instructions older than the faulting one are left alone, so they retire normally. This keeps architectural state precise.

When both flags are raised in the same cycle, the memory-stage instruction wins. It sits further down the pipe and is therefore older in program order.

The control is a two-state machine:

- `ST_IDLE` accepts exceptions. The transition *accept* moves it to `ST_HOLD` when either flag is seen.
- `ST_HOLD` ignores every flag, because these can only come from instructions that have already been squashed. It stays there until the fetch unit reports that the handler's first instruction has been fetched. The transition *release* then returns it to `ST_IDLE`.

Top module: `exc_ctrl`

## Requirements
- R1: After reset, and with no flag raised, every flush, `wb_suppress`, `epc_we`, `cause_we` and `redirect_valid` output is 0, and `cause_data` is 0.
- R2: In `ST_IDLE`, if `ex_ovf` is 1 and `mem_fault` is 0, all three flush outputs are 1 in that same cycle and `wb_suppress` is 0, so the older memory-stage instruction completes.
- R3: In `ST_IDLE`, if `mem_fault` is 1, all three flush outputs and `wb_suppress` are 1 in that same cycle.
- R4: When an exception is accepted, `epc_we` is 1 and `epc_data` equals the PC of the stage whose exception was chosen.
- R5: When an exception is accepted, `cause_we` is 1 and `cause_data` takes the value 1 for an overflow or 2 for a memory fault. It is 0 whenever nothing is accepted.
- R6: When an exception is accepted, `redirect_valid` is 1 and `redirect_pc` equals the parameter `HANDLER_VEC`, which defaults to 32'h8000_0180.
- R7: If both flags are raised in the same cycle in `ST_IDLE`, the memory fault is taken: cause 2, and `epc_data` equals `mem_pc`.
- R8: From the cycle after an acceptance, every flag is ignored and all outputs stay 0. This lasts up to and including the cycle in which `redir_fetched` is 1. In the cycle after that, a flag is accepted again.
- R9: An active-low reset returns the block to `ST_IDLE` from `ST_HOLD`, so a flag in the first cycle after reset is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ex_ovf | input | 1 | Overflow detected in the execute stage |
| ex_pc | input | XLEN | PC of the execute-stage instruction |
| mem_fault | input | 1 | Fault detected in the memory stage |
| mem_pc | input | XLEN | PC of the memory-stage instruction |
| redir_fetched | input | 1 | Fetch has taken the handler's first instruction |
| flush_ifid | output | 1 | Clear the IF/ID latch |
| flush_idex | output | 1 | Clear the ID/EX latch |
| flush_exmem | output | 1 | Clear the EX/MEM latch |
| wb_suppress | output | 1 | Block write-back of the memory-stage instruction |
| epc_we | output | 1 | Write enable for the exception PC register |
| epc_data | output | XLEN | PC of the faulting instruction |
| cause_we | output | 1 | Write enable for the cause register |
| cause_data | output | 2 | Reason code: 0 none, 1 overflow, 2 memory fault |
| redirect_valid | output | 1 | Steer fetch to the handler |
| redirect_pc | output | XLEN | Handler vector |

## Verification
The checker models `ST_HOLD` with its own busy flag, which it sets on `redirect_valid` and clears on `redir_fetched`. Its properties assume that `redir_fetched` is meaningful only while a redirect is outstanding, and that the PCs are stable during the cycle a flag is raised. The stimulus raises `redir_fetched` only after a redirect has been issued, with one exception: a single vector raises it while the block is waiting, together with a flag, to check that the flag is dropped. All inputs change on the falling edge, so every flag is settled at the edge that samples it.

// File: rtl/exc_pkg.sv
package exc_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'd0,
        CAUSE_OVF  = 2'd1,
        CAUSE_MEMF = 2'd2
    } cause_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } seq_state_e;

endpackage

// File: rtl/exc_prio_sel.sv
// Picks the oldest pending exception: the memory stage holds the older
// instruction, so its fault outranks an execute-stage overflow.
module exc_prio_sel
    import exc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            ex_ovf,
    input  logic [XLEN-1:0] ex_pc,
    input  logic            mem_fault,
    input  logic [XLEN-1:0] mem_pc,
    output logic            any_exc,
    output logic            sel_mem,
    output cause_e          cause,
    output logic [XLEN-1:0] pc
);
    always_comb begin
        any_exc = ex_ovf | mem_fault;
        sel_mem = mem_fault;
        if (mem_fault) begin
            cause = CAUSE_MEMF;
            pc    = mem_pc;
        end else if (ex_ovf) begin
            cause = CAUSE_OVF;
            pc    = ex_pc;
        end else begin
            cause = CAUSE_NONE;
            pc    = '0;
        end
    end
endmodule

// File: rtl/exc_seq_fsm.sv
// Two-state sequencer: accept in idle, then hold until the redirect lands.
module exc_seq_fsm
    import exc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_exc,
    input  logic redir_fetched,
    output logic take
);
    seq_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (any_exc)       state_d = ST_HOLD;  // accept
            ST_HOLD: if (redir_fetched) state_d = ST_IDLE;  // release
            default:                    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        take = 1'b0;
        unique case (state_q)
            ST_IDLE: take = any_exc;
            ST_HOLD: take = 1'b0;
            default: take = 1'b0;
        endcase
    end
endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
    import exc_pkg::*;
#(
    parameter int              XLEN        = 32,
    parameter logic [XLEN-1:0] HANDLER_VEC = 32'h8000_0180
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ex_ovf,
    input  logic [XLEN-1:0] ex_pc,
    input  logic            mem_fault,
    input  logic [XLEN-1:0] mem_pc,
    input  logic            redir_fetched,
    output logic            flush_ifid,
    output logic            flush_idex,
    output logic            flush_exmem,
    output logic            wb_suppress,
    output logic            epc_we,
    output logic [XLEN-1:0] epc_data,
    output logic            cause_we,
    output logic [1:0]      cause_data,
    output logic            redirect_valid,
    output logic [XLEN-1:0] redirect_pc
);
    logic            any_exc, sel_mem, take;
    cause_e          sel_cause;
    logic [XLEN-1:0] sel_pc;

    exc_prio_sel #(.XLEN(XLEN)) u_prio (
        .ex_ovf    (ex_ovf),
        .ex_pc     (ex_pc),
        .mem_fault (mem_fault),
        .mem_pc    (mem_pc),
        .any_exc   (any_exc),
        .sel_mem   (sel_mem),
        .cause     (sel_cause),
        .pc        (sel_pc)
    );

    exc_seq_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .any_exc       (any_exc),
        .redir_fetched (redir_fetched),
        .take          (take)
    );

    // Squash the faulting instruction and everything younger; for an EX
    // overflow the EX/MEM flush removes the faulting instruction's MEM/WB.
    always_comb begin
        flush_ifid     = take;
        flush_idex     = take;
        flush_exmem    = take;
        wb_suppress    = take & sel_mem;
        epc_we         = take;
        epc_data       = take ? sel_pc : '0;
        cause_we       = take;
        cause_data     = take ? sel_cause : CAUSE_NONE;
        redirect_valid = take;
        redirect_pc    = HANDLER_VEC;
    end
endmodule

// File: rtl/exc_ctrl_chk.sv
module exc_ctrl_chk #(
    parameter int              XLEN        = 32,
    parameter logic [XLEN-1:0] HANDLER_VEC = 32'h8000_0180
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ex_ovf,
    input logic [XLEN-1:0] ex_pc,
    input logic            mem_fault,
    input logic [XLEN-1:0] mem_pc,
    input logic            redir_fetched,
    input logic            flush_ifid,
    input logic            flush_idex,
    input logic            flush_exmem,
    input logic            wb_suppress,
    input logic            epc_we,
    input logic [XLEN-1:0] epc_data,
    input logic            cause_we,
    input logic [1:0]      cause_data,
    input logic            redirect_valid,
    input logic [XLEN-1:0] redirect_pc
);
    logic busy;
    always_ff @(posedge clk) begin
        if (!rst_n)                     busy <= 1'b0;
        else if (redirect_valid)        busy <= 1'b1;
        else if (busy && redir_fetched) busy <= 1'b0;
    end

    assert_ovf_flush_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && ex_ovf && !mem_fault) |->
            (flush_ifid && flush_idex && flush_exmem && !wb_suppress));

    assert_memf_suppress_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && mem_fault) |->
            (flush_ifid && flush_idex && flush_exmem && wb_suppress));

    assert_epc_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && ex_ovf && !mem_fault) |-> (epc_we && epc_data == ex_pc));

    assert_cause_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cause_we |-> (epc_we && cause_data != 2'd0));

    assert_vector_R6: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> (redirect_pc == HANDLER_VEC));

    assert_oldest_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && mem_fault && ex_ovf) |->
            (cause_data == 2'd2 && epc_data == mem_pc));

    assert_hold_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!redirect_valid && !epc_we && !flush_ifid && !wb_suppress));

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!ex_ovf && !mem_fault) |-> (!redirect_valid && !flush_exmem && !cause_we));
endmodule

bind exc_ctrl exc_ctrl_chk #(.XLEN(XLEN), .HANDLER_VEC(HANDLER_VEC)) u_chk (.*);

// File: tb/exc_ctrl_bench.sv
module exc_ctrl_bench;
    localparam int          XLEN = 32;
    localparam logic [31:0] HVEC = 32'h8000_0180;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            ex_ovf, mem_fault, redir_fetched;
    logic [XLEN-1:0] ex_pc, mem_pc;
    logic            flush_ifid, flush_idex, flush_exmem, wb_suppress;
    logic            epc_we, cause_we, redirect_valid;
    logic [XLEN-1:0] epc_data, redirect_pc;
    logic [1:0]      cause_data;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    exc_ctrl u_exc_ctrl (.*);

    typedef struct packed {
        logic        ex;
        logic        mem;
        logic        fet;
        logic [31:0] expc;
        logic [31:0] mempc;
        logic        take;
        logic        wb;
        logic [1:0]  cause;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,1'b0,32'h0000_0000,32'h0000_0000,1'b0,1'b0,2'd0}, // R1 idle
        '{1'b1,1'b0,1'b0,32'h0000_0100,32'h0000_00fc,1'b1,1'b0,2'd1}, // R2 ovf
        '{1'b1,1'b0,1'b0,32'h0000_0104,32'h0000_0100,1'b0,1'b0,2'd0}, // R8 hold
        '{1'b0,1'b1,1'b0,32'h0000_0108,32'h0000_0104,1'b0,1'b0,2'd0}, // R8 hold
        '{1'b1,1'b0,1'b1,32'h0000_010c,32'h0000_0108,1'b0,1'b0,2'd0}, // R8 release
        '{1'b0,1'b1,1'b0,32'h0000_0208,32'h0000_0204,1'b1,1'b1,2'd2}, // R3 memf
        '{1'b0,1'b0,1'b1,32'h0000_0000,32'h0000_0000,1'b0,1'b0,2'd0}, // R8 release
        '{1'b1,1'b1,1'b0,32'h0000_0300,32'h0000_02fc,1'b1,1'b1,2'd2}, // R7 both
        '{1'b0,1'b0,1'b1,32'h0000_0000,32'h0000_0000,1'b0,1'b0,2'd0}, // release
        '{1'b0,1'b0,1'b0,32'h0000_0000,32'h0000_0000,1'b0,1'b0,2'd0}, // R1 idle
        '{1'b1,1'b0,1'b0,32'h0000_0400,32'h0000_03fc,1'b1,1'b0,2'd1}, // R4 ovf
        '{1'b0,1'b0,1'b1,32'h0000_0000,32'h0000_0000,1'b0,1'b0,2'd0}  // release
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_vec(input vec_t v, input string tag);
        logic [31:0] exp_epc;
        exp_epc = !v.take ? 32'h0 : (v.cause == 2'd2 ? v.mempc : v.expc);
        check({tag, " flush_ifid R2/R3"},  {31'd0, flush_ifid},  {31'd0, v.take});
        check({tag, " flush_idex R2/R3"},  {31'd0, flush_idex},  {31'd0, v.take});
        check({tag, " flush_exmem R2/R3"}, {31'd0, flush_exmem}, {31'd0, v.take});
        check({tag, " wb_suppress R3"},    {31'd0, wb_suppress}, {31'd0, v.wb});
        check({tag, " epc_we R4"},         {31'd0, epc_we},      {31'd0, v.take});
        if (v.take) check({tag, " epc_data R4"}, epc_data, exp_epc);
        check({tag, " cause_we R5"},       {31'd0, cause_we},    {31'd0, v.take});
        check({tag, " cause_data R5"},     {30'd0, cause_data},  {30'd0, v.cause});
        check({tag, " redirect_valid R6"}, {31'd0, redirect_valid}, {31'd0, v.take});
        if (v.take) check({tag, " redirect_pc R6"}, redirect_pc, HVEC);
    endtask

    task automatic drive(input vec_t v);
        @(negedge clk);
        ex_ovf = v.ex; mem_fault = v.mem; redir_fetched = v.fet;
        ex_pc = v.expc; mem_pc = v.mempc;
        #1;
    endtask

    initial begin
        rst_n = 1'b0; ex_ovf = 0; mem_fault = 0; redir_fetched = 0;
        ex_pc = '0; mem_pc = '0;
        repeat (3) @(posedge clk);
        #1;
        check_vec('0, "reset R1");
        @(negedge clk); rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            check_vec(VECS[i], $sformatf("vec%0d", i));
        end

        // R9: reset while holding, then a flag right after reset is accepted
        drive('{1'b1,1'b0,1'b0,32'h0000_0500,32'h0,1'b1,1'b0,2'd1});
        check_vec('{1'b1,1'b0,1'b0,32'h0000_0500,32'h0,1'b1,1'b0,2'd1}, "pre-reset R9");
        drive('{1'b1,1'b0,1'b0,32'h0000_0504,32'h0,1'b0,1'b0,2'd0});
        check_vec('{1'b1,1'b0,1'b0,32'h0000_0504,32'h0,1'b0,1'b0,2'd0}, "holding R8");
        @(negedge clk); rst_n = 1'b0; ex_ovf = 0;
        @(negedge clk); rst_n = 1'b1;
        drive('{1'b0,1'b1,1'b0,32'h0,32'h0000_0600,1'b1,1'b1,2'd2});
        check_vec('{1'b0,1'b1,1'b0,32'h0,32'h0000_0600,1'b1,1'b1,2'd2}, "post-reset R9");

        // R8: a long hold without release keeps ignoring flags
        for (int k = 0; k < 5; k++) begin
            drive('{1'b1,1'b1,1'b0,32'h0000_0700,32'h0000_06fc,1'b0,1'b0,2'd0});
            check_vec('{1'b1,1'b1,1'b0,32'h0000_0700,32'h0000_06fc,1'b0,1'b0,2'd0},
                      "long hold R8");
        end
        drive('{1'b0,1'b0,1'b1,32'h0,32'h0,1'b0,1'b0,2'd0});
        drive('{1'b1,1'b0,1'b0,32'h0000_0800,32'h0000_07fc,1'b1,1'b0,2'd1});
        check_vec('{1'b1,1'b0,1'b0,32'h0000_0800,32'h0000_07fc,1'b1,1'b0,2'd1},
                  "after release R8");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R1 actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule